// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides which receive message buffers may take a received CAN frame. The host supplies up to sixteen programmed buffer identifiers and a flag for each buffer that marks it as an active receive buffer. The filter holds three 32-bit mask words. One mask is shared by every buffer except the two highest-numbered ones, and each of those two has a private mask. Software reaches the masks through a small synchronous register port in 16-bit halves.

When a frame identifier is presented with `frm_valid`, the filter compares it against every buffer under that buffer's mask. One cycle later it reports the set of matching buffers, whether any buffer matched, and the lowest-numbered matching buffer. Standard frames are compared only on their 11 base bits and the IDE bit. Extended frames also use the 18 extension bits. Remote frames are always turned away.

Buffer identifiers and mask words share one 32-bit layout:
- bits 31:21 hold identifier bits 28..18, the base part;
- bit 20 is the RTR/SRR slot;
- bit 19 is IDE;
- bits 18:1 hold identifier bits 17..0, the extension part;
- bit 0 is the RTR slot.

Top module: `can_acc_filter`

## Requirements
- R1: After reset, every mask reads 0xFFEF in its high half and 0xFFFE in its low half. After reset, res_valid, res_hit, res_vec and res_idx are all zero.
- R2: On a mask write, bit 4 of a high half (word bit 20) and bit 0 of a low half (word bit 0) always read 0, and bit 3 of a high half (word bit 19) always reads 1. All other bits read back as written. The register map is:
  - address 0: shared mask high half;
  - address 1: shared mask low half;
  - address 2: buffer 14 mask high half;
  - address 3: buffer 14 mask low half;
  - address 4: buffer 15 mask high half;
  - address 5: buffer 15 mask low half.
  Addresses 6 and 7 read 0 and ignore writes.
- R3: A mask bit of 1 requires the frame bit to equal the buffer bit, and a mask bit of 0 lets that bit differ. Buffer identifier bits 20 and 0 never affect the result.
- R4: Buffers 0 to 13 use the shared mask. Buffer 14 uses the mask at addresses 2 and 3, and buffer 15 uses the mask at addresses 4 and 5.
- R5: For a standard frame (frm_ide = 0), only frame bits 28..18 and IDE are compared. Frame bits 17..0 and buffer bits 18:1 have no effect.
- R6: The IDE bit is always compared. A standard frame never matches a buffer whose bit 19 is 1, and an extended frame never matches a buffer whose bit 19 is 0.
- R7: A frame with frm_rtr = 1 never sets any bit of res_vec, whatever its identifier.
- R8: A buffer whose buf_active bit is 0 never appears in res_vec.
- R9: res_vec shows every matching buffer, and res_hit is the OR of res_vec. res_idx is the lowest set index of res_vec, or 0 when res_vec is empty.
- R10: The results for a frame presented with frm_valid appear in the next cycle, with res_valid = 1. In a cycle following no frame, res_valid, res_hit, res_vec and res_idx are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW (3) | Mask register half select |
| reg_wr | input | 1 | Write strobe for the addressed half |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data of the addressed half |
| buf_id | input | NBUF*32 (512) | Programmed identifier words, buffer b at bits b*32+31 : b*32 |
| buf_active | input | NBUF (16) | Buffer takes part in filtering when its bit is 1 |
| frm_valid | input | 1 | A received identifier is presented this cycle |
| frm_id | input | 29 | Received identifier; a standard frame uses bits 28:18 |
| frm_ide | input | 1 | 1 for an extended frame |
| frm_rtr | input | 1 | 1 for a remote frame |
| res_valid | output | 1 | Results below belong to the frame of the previous cycle |
| res_hit | output | 1 | At least one buffer accepted the frame |
| res_vec | output | NBUF (16) | One bit per accepting buffer |
| res_idx | output | clog2(NBUF) (4) | Lowest accepting buffer |

## Verification
The hardest case to reach is a frame that matches a buffer only because a private mask ignores a bit the shared mask would check. A second hard case is a frame that sits in the same cycle as a mask write, where the old mask must still decide. Random identifiers almost never hit any buffer. The stimulus therefore builds each frame from a chosen buffer's word and flips zero to two bits in it. It scatters mask writes, including ones with cleared bits, in among the frames. A behavioural model checks every cycle, so each of these coincidences is checked whenever it happens.

// File: rtl/can_acc_filter.sv
module can_acc_filter #(
  parameter int NBUF = 16,
  parameter int AW = 3,
  localparam int IW = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [NBUF*32-1:0] buf_id,
  input  logic [NBUF-1:0]   buf_active,
  input  logic              frm_valid,
  input  logic [28:0]       frm_id,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [NBUF-1:0]   res_vec,
  output logic [IW-1:0]     res_idx
);

  localparam logic [15:0] HI_RST = 16'hFFEF;
  localparam logic [15:0] LO_RST = 16'hFFFE;
  localparam logic [31:0] STD_KEEP = 32'hFFF8_0000;
  localparam int NREG = 6;

  logic [31:0] msk [3];
  logic [31:0] rxw, kind;
  logic [NBUF-1:0] match;
  logic [IW-1:0] first;
  logic [1:0] sel;
  logic in_map;

  assign in_map = int'(reg_addr) < NREG;
  assign sel = 2'(reg_addr >> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) msk[i] <= {HI_RST, LO_RST};
    end else if (reg_wr && in_map) begin
      if (reg_addr[0]) msk[sel][15:0] <= {reg_wdata[15:1], 1'b0};
      else msk[sel][31:16] <= {reg_wdata[15:5], 2'b01, reg_wdata[2:0]};
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_map) reg_rdata = reg_addr[0] ? msk[sel][15:0] : msk[sel][31:16];
  end

  assign rxw  = {frm_id[28:18], 1'b0, frm_ide, frm_id[17:0], 1'b0};
  assign kind = frm_ide ? 32'hFFFF_FFFF : STD_KEEP;

  for (genvar b = 0; b < NBUF; b++) begin : g_cmp
    logic [31:0] m;
    assign m = (b == NBUF-1) ? msk[2] : (b == NBUF-2) ? msk[1] : msk[0];
    assign match[b] = buf_active[b] & ~frm_rtr &
                      ~|((rxw ^ buf_id[b*32 +: 32]) & m & kind);
  end

  always_comb begin
    first = '0;
    for (int i = NBUF-1; i >= 0; i--) if (match[i]) first = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_vec   <= '0;
      res_idx   <= '0;
    end else begin
      res_valid <= frm_valid;
      res_hit   <= frm_valid & (|match);
      res_vec   <= frm_valid ? match : '0;
      res_idx   <= frm_valid ? first : '0;
    end
  end

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_map && !reg_addr[0]) |-> (reg_rdata[4:3] == 2'b01));
  a_r2_lo_rtr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_map && reg_addr[0]) |-> !reg_rdata[0]);
  a_r7_no_remote: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_rtr) |=> (res_vec == '0 && !res_hit));
  a_r8_inactive_out: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> ((res_vec & ~$past(buf_active)) == '0));
  a_r9_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_vec[res_idx] && ((res_vec & ((NBUF'(1) << res_idx) - NBUF'(1))) == '0)));
  a_r9_hit_or: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit == (|res_vec));
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> res_valid);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_vec == '0 && res_idx == '0));

endmodule

// File: tb/test_can_acc_filter.sv
`timescale 1ns/1ps
module test_can_acc_filter;
  localparam int NB = 16;

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic [NB*32-1:0] buf_id;
  logic [NB-1:0] buf_active = '1;
  logic frm_valid = 0, frm_ide = 0, frm_rtr = 0;
  logic [28:0] frm_id = 0;
  logic res_valid, res_hit;
  logic [NB-1:0] res_vec;
  logic [3:0] res_idx;

  logic [31:0] bid [NB];
  logic [31:0] mm [3];
  logic e_valid, e_hit;
  logic [NB-1:0] e_vec;
  logic [3:0] e_idx;
  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  always_comb for (int b = 0; b < NB; b++) buf_id[b*32 +: 32] = bid[b];

  can_acc_filter i_can_acc_filter (
    .clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
    .buf_id, .buf_active, .frm_valid, .frm_id, .frm_ide, .frm_rtr,
    .res_valid, .res_hit, .res_vec, .res_idx);

  function automatic bit accepts(int b);
    int mi;
    logic [31:0] w, m;
    mi = (b == 15) ? 2 : (b == 14) ? 1 : 0;
    w = bid[b]; m = mm[mi];
    if (!buf_active[b] || frm_rtr) return 0;
    if (w[19] != frm_ide) return 0;
    for (int k = 0; k < 11; k++)
      if (m[21+k] && frm_id[18+k] != w[21+k]) return 0;
    if (frm_ide)
      for (int k = 0; k < 18; k++)
        if (m[1+k] && frm_id[k] != w[1+k]) return 0;
    return 1;
  endfunction

  function automatic logic [15:0] model_read(logic [2:0] a);
    if (a > 5) return 16'h0;
    return a[0] ? mm[a/2][15:0] : mm[a/2][31:16];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) mm[i] <= 32'hFFEF_FFFE;
      e_valid <= 0; e_hit <= 0; e_vec <= '0; e_idx <= '0;
    end else begin
      logic [NB-1:0] v;
      int lo;
      v = '0; lo = -1;
      if (frm_valid)
        for (int b = 0; b < NB; b++)
          if (accepts(b)) begin v[b] = 1; if (lo < 0) lo = b; end
      e_valid <= frm_valid;
      e_vec <= v;
      e_hit <= (lo >= 0);
      e_idx <= (lo >= 0) ? 4'(lo) : 4'd0;
      if (reg_wr && reg_addr < 6) begin
        logic [15:0] t;
        t = reg_wdata;
        if (reg_addr[0]) begin t[0] = 0; mm[reg_addr/2][15:0] <= t; end
        else begin t[4] = 0; t[3] = 1; mm[reg_addr/2][31:16] <= t; end
      end
    end
  end

  always @(negedge clk) if (!done) begin
    logic [15:0] er;
    checks++;
    if (!rst_n) begin
      if (res_valid || res_hit || res_vec != 0 || res_idx != 0) begin
        errors++;
        $display("FAIL R1 outputs in reset: actual %b%b %h %h expected 00 0000 0",
                 res_valid, res_hit, res_vec, res_idx);
      end
    end else begin
      if ({res_valid, res_hit, res_vec, res_idx} !== {e_valid, e_hit, e_vec, e_idx}) begin
        errors++;
        $display("FAIL %s result: actual v%b h%b vec %h idx %0d expected v%b h%b vec %h idx %0d",
                 cur_req, res_valid, res_hit, res_vec, res_idx, e_valid, e_hit, e_vec, e_idx);
      end
      checks++;
      er = model_read(reg_addr);
      if (reg_rdata !== er) begin
        errors++;
        $display("FAIL %s rdata addr %0d: actual %h expected %h", cur_req, reg_addr, reg_rdata, er);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    reg_wr = 0; frm_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1; step();
  endtask

  task automatic rd(input logic [2:0] a);
    reg_addr = a; step();
  endtask

  task automatic frame(input logic [28:0] id, input logic ide, input logic rtr);
    frm_id = id; frm_ide = ide; frm_rtr = rtr; frm_valid = 1; step();
  endtask

  function automatic logic [31:0] mkw(input logic [28:0] id, input logic ide);
    return {id[28:18], 1'b0, ide, id[17:0], 1'b0};
  endfunction

  task automatic clear_bufs();
    for (int b = 0; b < NB; b++) bid[b] = 32'h0000_0000 | (32'(b) << 21) | 32'h0008_0000;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    clear_bufs();
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd(3'(a));

    cur_req = "R2";
    wr(0, 16'h0000); rd(0);
    wr(1, 16'hFFFF); rd(1);
    wr(0, 16'hFFFF); rd(0);
    wr(3, 16'h5555); rd(3);
    wr(4, 16'hA5A5); rd(4);
    wr(6, 16'h1234); rd(6); rd(7);
    wr(3, 16'hFFFF); wr(4, 16'hFFFF);

    cur_req = "R3";
    bid[3] = mkw(29'h0ABC_1234, 1) | 32'h0010_0001;
    frame(29'h0ABC_1234, 1, 0);
    frame(29'h0ABC_1235, 1, 0);
    wr(1, 16'h0000);
    frame(29'h0ABC_1235, 1, 0);
    frame(29'h0ABC_1234, 1, 0);
    wr(1, 16'hFFFF);

    cur_req = "R4";
    bid[14] = mkw(29'h1555_0000, 1);
    bid[15] = mkw(29'h1555_0000, 1);
    bid[2]  = mkw(29'h1555_0000, 1);
    wr(3, 16'h0000);
    frame(29'h1555_0077, 1, 0);
    frame(29'h1555_0000, 1, 0);
    wr(3, 16'hFFFF); wr(5, 16'h0000);
    frame(29'h1555_0077, 1, 0);
    wr(5, 16'hFFFF);
    clear_bufs();

    cur_req = "R5";
    bid[6] = mkw({11'h123, 18'h0}, 0);
    frame({11'h123, 18'h3ABCD}, 0, 0);
    frame({11'h122, 18'h0}, 0, 0);

    cur_req = "R6";
    frame({11'h123, 18'h0}, 1, 0);
    bid[7] = mkw({11'h123, 18'h0}, 1);
    frame({11'h123, 18'h0}, 0, 0);

    cur_req = "R7";
    frame({11'h123, 18'h0}, 0, 1);
    frame({11'h123, 18'h0}, 1, 1);

    cur_req = "R8";
    buf_active[6] = 0;
    frame({11'h123, 18'h0}, 0, 0);
    buf_active = '1;

    cur_req = "R9";
    for (int b = 4; b < NB; b += 3) bid[b] = mkw(29'h00F0_F0F0, 1);
    frame(29'h00F0_F0F0, 1, 0);
    buf_active[4] = 0;
    frame(29'h00F0_F0F0, 1, 0);
    buf_active = '1;
    clear_bufs();

    cur_req = "R10";
    for (int n = 0; n < 4000; n++) begin
      int pick;
      logic [31:0] w;
      logic [28:0] id;
      if (n % 50 == 0) for (int b = 0; b < NB; b++) bid[b] = $urandom;
      if (n % 37 == 0) buf_active = 16'($urandom) | 16'h8421;
      if ($urandom_range(0, 4) == 0) begin
        reg_addr = 3'($urandom_range(0, 7));
        reg_wdata = 16'($urandom) | 16'($urandom);
        reg_wr = 1;
      end else reg_addr = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 5) != 0) begin
        pick = $urandom_range(0, NB-1);
        w = bid[pick];
        id = {w[31:21], w[18:1]};
        for (int f = $urandom_range(0, 2); f > 0; f--) id[$urandom_range(0, 28)] ^= 1'b1;
        frm_id = id;
        frm_ide = ($urandom_range(0, 9) == 0) ? ~w[19] : w[19];
        frm_rtr = ($urandom_range(0, 9) == 0);
        frm_valid = 1;
      end
      step();
    end

    step(); step();
    done = 1;
    summary();
  end
endmodule